// File: doc/BRIEF.md
# Display Flash and Dimming Blank Generator

This block drives the active-low blank input of a character display. It has two modes. In flash mode it makes a slow square blink whose rate is set in whole hertz. In dim mode it makes a fast pulse-width-modulated blank. The length of the blank pulse in each period sets how bright the display looks. Blanking only gates the display's light output, so the stored characters are never touched.

All timing comes from one time base: a prescaler turns the system clock into ticks (one microsecond at the default settings), and a period counter counts ticks. Each period starts with the blank pulse (output low) and ends with the display enabled (output high). The mode, the flash rate and the dim level are sampled once, at the start of each period. A setting change therefore never cuts a pulse short or stretches it. The settings are plain control pins with no handshake, because they are levels and not a data stream; the single output is a registered level.

Top module: `blank_gen`

## Requirements
- R1: While `rst` is high, `blank_n` is held high (display enabled) from the first clock edge onwards.
- R2: The time base advances by one tick every `TICK_DIV` clock cycles, so every low or high run of `blank_n` lasts a whole multiple of `TICK_DIV` cycles.
- R3: In dim mode a period is `DIM_PERIOD` ticks long: `blank_n` is low for the first W ticks and high for the remaining `DIM_PERIOD - W` ticks.
- R4: The dim pulse width is W = `DIM_MIN` + floor(`dim_level` * (`DIM_PERIOD` - 2*`DIM_MIN`) / 255), with `dim_level` an unsigned 8-bit code. Code 0 gives `DIM_MIN`, code 255 gives `DIM_PERIOD - DIM_MIN`, and no period is ever fully blanked or fully lit.
- R5: In flash mode a period is P = floor(`FLASH_TICKS_1HZ` / rate) ticks, with `flash_rate` an unsigned 4-bit rate in hertz. `blank_n` is low for the first floor(P/2) ticks and high for the rest.
- R6: A `flash_rate` code of 0 acts as 1 Hz, and codes 11 to 15 act as 10 Hz.
- R7: Mode and setting changes take effect only at the next period boundary. A period already in progress finishes with the low and high lengths that were latched when it started.
- R8: `flash_sel` = 1 selects flash mode and `flash_sel` = 0 selects dim mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| flash_sel | input | 1 | 1 selects flash mode, 0 selects dim mode |
| flash_rate | input | 4 | Flash rate in Hz; saturates to the range 1 to 10 |
| dim_level | input | 8 | Dim code; a higher code gives a longer blank pulse |
| blank_n | output | 1 | Registered blank output, active low |

## Verification
The bench builds the block with `TICK_DIV` = 2, `DIM_PERIOD` = 20, `DIM_MIN` = 2 and `FLASH_TICKS_1HZ` = 400. This shrinks a 1 Hz flash period to 800 cycles and a dim period to 40 cycles, so every flash rate and both ends of the dim code range fit in a short run. With these values a 3 Hz flash period has an odd tick count, which tests the uneven low/high split. The small prescale divisor also means a change of mode or level mid-period can be placed inside a long pulse, and the bench can check that the pulse finishes at its latched length.

// File: rtl/blank_pkg.sv
package blank_pkg;

  localparam int unsigned RATE_W    = 4;
  localparam int unsigned LEVEL_W   = 8;
  localparam int unsigned RATE_LO   = 1;
  localparam int unsigned RATE_HI   = 10;
  localparam int unsigned LEVEL_TOP = 255;

  // Saturate a requested flash rate into the supported window (R6)
  function automatic logic [RATE_W-1:0] clamp_rate(input logic [RATE_W-1:0] r);
    if (r < RATE_W'(RATE_LO)) return RATE_W'(RATE_LO);
    if (r > RATE_W'(RATE_HI)) return RATE_W'(RATE_HI);
    return r;
  endfunction

endpackage

// File: rtl/blank_prescaler.sv
module blank_prescaler #(
  parameter int unsigned TICK_DIV = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(TICK_DIV);
      logic [PW-1:0] cnt;

      assign tick = (cnt == PW'(TICK_DIV - 1));

      always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + PW'(1);
      end
    end
  endgenerate

endmodule

// File: rtl/blank_setting_map.sv
module blank_setting_map
  import blank_pkg::*;
#(
  parameter int unsigned CNT_W           = 20,
  parameter int unsigned DIM_PERIOD      = 200,
  parameter int unsigned DIM_MIN         = 4,
  parameter int unsigned FLASH_TICKS_1HZ = 1000000
) (
  input  logic               flash_sel,
  input  logic [RATE_W-1:0]  flash_rate,
  input  logic [LEVEL_W-1:0] dim_level,
  output logic [CNT_W-1:0]   nxt_per,
  output logic [CNT_W-1:0]   nxt_low
);

  localparam int unsigned SPAN   = DIM_PERIOD - 2 * DIM_MIN;
  localparam int unsigned PROD_W = CNT_W + LEVEL_W;
  localparam int unsigned N_RATE = 2 ** RATE_W;

  // Flash period per rate code, folded to constants at elaboration
  logic [CNT_W-1:0] per_tbl [N_RATE];

  generate
    for (genvar k = 0; k < N_RATE; k++) begin : g_tbl
      localparam int unsigned DIVISOR = (k == 0) ? 1 : k;
      localparam int unsigned PER_K   =
        (k >= RATE_LO && k <= RATE_HI) ? FLASH_TICKS_1HZ / DIVISOR : 0;
      assign per_tbl[k] = CNT_W'(PER_K);
    end
  endgenerate

  logic [RATE_W-1:0]  rate_c;
  logic [CNT_W-1:0]   flash_per;
  logic [PROD_W-1:0]  prod;
  logic [CNT_W-1:0]   dim_w;

  assign rate_c    = clamp_rate(flash_rate);
  assign flash_per = per_tbl[rate_c];
  assign prod      = PROD_W'(dim_level) * PROD_W'(SPAN);
  assign dim_w     = CNT_W'(PROD_W'(DIM_MIN) + prod / PROD_W'(LEVEL_TOP));

  always_comb begin
    if (flash_sel) begin
      nxt_per = flash_per;
      nxt_low = flash_per >> 1;
    end else begin
      nxt_per = CNT_W'(DIM_PERIOD);
      nxt_low = dim_w;
    end
  end

endmodule

// File: rtl/blank_period_ctr.sv
module blank_period_ctr #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cur_per,
  input  logic [CNT_W-1:0] cur_low,
  output logic [CNT_W-1:0] ph_cnt,
  output logic             boundary,
  output logic             blank_n
);

  assign boundary = tick && (ph_cnt == cur_per - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_cnt  <= '0;
      blank_n <= 1'b1;
    end else begin
      if (tick) ph_cnt <= boundary ? '0 : ph_cnt + CNT_W'(1);
      blank_n <= (ph_cnt >= cur_low);
    end
  end

endmodule

// File: rtl/blank_gen.sv
module blank_gen
  import blank_pkg::*;
#(
  parameter int unsigned TICK_DIV        = 100,
  parameter int unsigned DIM_PERIOD      = 200,
  parameter int unsigned DIM_MIN         = 4,
  parameter int unsigned FLASH_TICKS_1HZ = 1000000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flash_sel,
  input  logic [RATE_W-1:0]  flash_rate,
  input  logic [LEVEL_W-1:0] dim_level,
  output logic               blank_n
);

  localparam int unsigned MAX_PER = (FLASH_TICKS_1HZ > DIM_PERIOD) ? FLASH_TICKS_1HZ : DIM_PERIOD;
  localparam int unsigned CNT_W   = $clog2(MAX_PER + 1);

  logic             tick;
  logic             boundary;
  logic [CNT_W-1:0] ph_cnt;
  logic [CNT_W-1:0] nxt_per, nxt_low;
  logic [CNT_W-1:0] cur_per, cur_low;

  blank_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  blank_setting_map #(
    .CNT_W          (CNT_W),
    .DIM_PERIOD     (DIM_PERIOD),
    .DIM_MIN        (DIM_MIN),
    .FLASH_TICKS_1HZ(FLASH_TICKS_1HZ)
  ) u_map (
    .flash_sel (flash_sel),
    .flash_rate(flash_rate),
    .dim_level (dim_level),
    .nxt_per   (nxt_per),
    .nxt_low   (nxt_low)
  );

  // Settings are captured only when a period wraps
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_per <= CNT_W'(DIM_PERIOD);
      cur_low <= CNT_W'(DIM_MIN);
    end else if (boundary) begin
      cur_per <= nxt_per;
      cur_low <= nxt_low;
    end
  end

  blank_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cur_per (cur_per),
    .cur_low (cur_low),
    .ph_cnt  (ph_cnt),
    .boundary(boundary),
    .blank_n (blank_n)
  );

endmodule

// File: rtl/blank_gen_chk.sv
module blank_gen_chk #(
  parameter int unsigned TICK_DIV        = 100,
  parameter int unsigned CNT_W           = 20,
  parameter int unsigned DIM_PERIOD      = 200,
  parameter int unsigned FLASH_TICKS_1HZ = 1000000
) (
  input logic             clk,
  input logic             rst,
  input logic             blank_n,
  input logic             tick,
  input logic             boundary,
  input logic [CNT_W-1:0] ph_cnt,
  input logic [CNT_W-1:0] cur_per,
  input logic [CNT_W-1:0] cur_low
);

  localparam int unsigned GW = $clog2(TICK_DIV + 1);

  logic [GW-1:0] gap;
  logic          rst_seen;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst)       gap <= '0;
    else if (tick) gap <= '0;
    else           gap <= gap + GW'(1);
  end

  // R1: output held high once reset has been sampled
  always @(negedge clk) begin
    if (rst && rst_seen === 1'b1)
      a_r1_blank_high_in_reset: assert (blank_n === 1'b1);
  end

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap == GW'(TICK_DIV - 1)));

  a_r3_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    ph_cnt < cur_per);

  a_r4_no_full_or_empty: assert property (@(posedge clk) disable iff (rst)
    (cur_low != '0) && (cur_low < cur_per));

  a_r6_period_legal: assert property (@(posedge clk) disable iff (rst)
    (cur_per == CNT_W'(DIM_PERIOD)) ||
    ((cur_per >= CNT_W'(FLASH_TICKS_1HZ / 10)) && (cur_per <= CNT_W'(FLASH_TICKS_1HZ))));

  a_r7_settings_hold: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(cur_per) && $stable(cur_low)));

endmodule

bind blank_gen blank_gen_chk #(
  .TICK_DIV       (TICK_DIV),
  .CNT_W          (CNT_W),
  .DIM_PERIOD     (DIM_PERIOD),
  .FLASH_TICKS_1HZ(FLASH_TICKS_1HZ)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .blank_n (blank_n),
  .tick    (tick),
  .boundary(boundary),
  .ph_cnt  (ph_cnt),
  .cur_per (cur_per),
  .cur_low (cur_low)
);

// File: tb/tb_blank_gen.sv
module tb_blank_gen;

  localparam int TD   = 2;
  localparam int DPER = 20;
  localparam int DMIN = 2;
  localparam int F1   = 400;

  typedef struct {
    int    lo;
    int    hi;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flash_sel = 1'b0;
  logic [3:0] flash_rate = 4'd1;
  logic [7:0] dim_level = 8'd0;
  logic       blank_n;

  int   n_chk  = 0;
  int   n_fail = 0;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  blank_gen #(
    .TICK_DIV(TD), .DIM_PERIOD(DPER), .DIM_MIN(DMIN), .FLASH_TICKS_1HZ(F1)
  ) dut (
    .clk(clk), .rst(rst), .flash_sel(flash_sel),
    .flash_rate(flash_rate), .dim_level(dim_level), .blank_n(blank_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected values straight from R4, R5, R6
  function automatic int dim_w(input int lvl);
    return DMIN + (lvl * (DPER - 2 * DMIN)) / 255;
  endfunction

  function automatic int flash_p(input int r);
    int rc = (r < 1) ? 1 : ((r > 10) ? 10 : r);
    return F1 / rc;
  endfunction

  task automatic wait_fall();
    logic prev;
    do begin
      prev = blank_n;
      @(negedge clk);
    end while (!(prev === 1'b1 && blank_n === 1'b0));
  endtask

  task automatic count_run(input logic lvl, inout int n);
    forever begin
      @(negedge clk);
      if (blank_n !== lvl) break;
      n++;
    end
  endtask

  // Driver: apply a setting and push the expected run lengths
  task automatic run_case(input logic fs, input int rate, input int lvl, input string tag);
    exp_t e;
    flash_sel  = fs;
    flash_rate = 4'(rate);
    dim_level  = 8'(lvl);
    if (fs) begin
      e.lo = (flash_p(rate) / 2) * TD;
      e.hi = (flash_p(rate) - flash_p(rate) / 2) * TD;
    end else begin
      e.lo = dim_w(lvl) * TD;
      e.hi = (DPER - dim_w(lvl)) * TD;
    end
    e.tag = tag;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  // Monitor: skip one possibly stale period, then measure one full period
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      begin
        int lo, hi;
        exp_t e;
        wait_fall();
        wait_fall();
        lo = 1;
        count_run(1'b0, lo);
        hi = 1;
        count_run(1'b1, hi);
        e = sb_q[0];
        check({e.tag, " low run"}, lo, e.lo);
        check({e.tag, " high run"}, hi, e.hi);
        void'(sb_q.pop_front());
      end
    end
  end

  // Change a setting part-way through a low pulse (R7)
  task automatic mid_change(input logic fs2, input int lvl2, input int old_lo,
                            input int old_hi, input int new_lo, input string tag);
    int lo, hi, lo2;
    wait_fall();
    lo = 1;
    repeat (3) begin @(negedge clk); lo++; end
    flash_sel = fs2;
    dim_level = 8'(lvl2);
    count_run(1'b0, lo);
    hi = 1;
    count_run(1'b1, hi);
    lo2 = 1;
    count_run(1'b0, lo2);
    check({tag, " old low kept"}, lo, old_lo);
    check({tag, " old high kept"}, hi, old_hi);
    check({tag, " new low at boundary"}, lo2, new_lo);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 blank high in reset", int'(blank_n), 1);
    rst = 1'b0;
    @(negedge clk);

    // R3 R4: dim extremes and middle codes; R2 via TD-scaled runs
    run_case(1'b0, 1, 0,   "R4 dim code 0");
    run_case(1'b0, 1, 255, "R4 dim code 255");
    run_case(1'b0, 1, 128, "R3 dim code 128");
    run_case(1'b0, 1, 100, "R2 dim code 100");
    // R5: flash rates, including odd period
    run_case(1'b1, 1,  0, "R5 flash 1Hz");
    run_case(1'b1, 2,  0, "R5 flash 2Hz");
    run_case(1'b1, 3,  0, "R5 flash 3Hz");
    run_case(1'b1, 10, 0, "R5 flash 10Hz");
    // R6: saturation
    run_case(1'b1, 0,  0, "R6 rate 0 clamps to 1");
    run_case(1'b1, 15, 0, "R6 rate 15 clamps to 10");

    // R7: level change inside a long dim pulse
    run_case(1'b0, 1, 255, "R7 setup dim 255");
    mid_change(1'b0, 0, dim_w(255) * TD, (DPER - dim_w(255)) * TD,
               dim_w(0) * TD, "R7 level change");

    // R8: switch from flash to dim mid-pulse
    run_case(1'b1, 10, 0, "R8 setup flash 10Hz");
    mid_change(1'b0, 100, (flash_p(10) / 2) * TD,
               (flash_p(10) - flash_p(10) / 2) * TD,
               dim_w(100) * TD, "R8 mode switch");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule